// File: doc/BRIEF.md
# Rule Table Range Eraser

This block owns the erase command word of a packet-classification rule table. Software writes one 32-bit word that names a first and a last entry index and sets the execute flag. The controller then writes an all-zero entry, valid flag included, to each index of that span in ascending order, one entry per clock. While it works, bit 0 of the same word reads back as one. Software polls that bit until it reads zero. A second small register keeps one lookup-enable bit per rule block. Software clears this bit before an erase and sets it again afterwards. Every erase write also presents the number of the block it falls in, which is the entry index divided by the block size.

The controller has three states. **ST_SWEEP** clears one entry per cycle. **ST_EMPTY** is a one-cycle busy state taken when the last index is below the first. **ST_IDLE** waits for a command. Transitions:
- IDLE→SWEEP on an accepted execute write whose range is not empty.
- IDLE→EMPTY on an accepted execute write whose last index is below its first.
- SWEEP→IDLE in the cycle that writes the last index.
- EMPTY→IDLE unconditionally.

Reset enters SWEEP with the range set to the whole table, so every entry is erased once after power-up.

Top module: `acl_range_clear`

## Requirements
- R1: After reset the controller erases every entry from 0 to NUM_BLOCKS*BLOCK_SIZE-1 exactly once, one per cycle. During this erase the readback shows first index 0, last index NUM_BLOCKS*BLOCK_SIZE-1 and bit 0 set.
- R2: Command word layout: bit 0 is execute, the first index is at bits [1 +: IDX_W] and the last index is at bits [12 +: IDX_W]. Readback uses the same layout, with bit 0 showing busy and all other bits zero.
- R3: An accepted execute write erases every index from first to last inclusive exactly once, in ascending order, one per cycle, and touches no other index.
- R4: Bit 0 reads one for exactly last-first+1 cycles after the accepting edge and then reads zero.
- R5: A command whose first index equals its last index erases that single entry and is busy for one cycle.
- R6: A command whose last index is below its first erases nothing and is busy for exactly one cycle.
- R7: A command write that arrives while busy is ignored: the stored range, the readback and the span being erased do not change.
- R8: A command write with bit 0 clear stores the range fields, starts no erase and leaves bit 0 at zero.
- R9: During every erase write, the block output equals the entry index divided by BLOCK_SIZE and the write data is all zero.
- R10: The lookup-enable register has one bit per block, resets to zero, loads the write data on a write strobe, and is not changed by an erase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_wr | input | 1 | Write strobe for the command word |
| cmd_wdata | input | 32 | Command word: execute, first index, last index |
| cmd_rdata | output | 32 | Readback of the stored range with busy in bit 0 |
| lut_wr | input | 1 | Write strobe for the lookup-enable register |
| lut_wdata | input | NUM_BLOCKS | New lookup-enable bits |
| lut_en | output | NUM_BLOCKS | Lookup enable, one bit per block |
| mem_we | output | 1 | Rule memory write enable |
| mem_addr | output | IDX_W | Entry index being erased |
| mem_blk | output | BLK_W | Block that holds mem_addr |
| mem_wdata | output | ENTRY_W | Entry data written (always zero) |

## Verification
The hardest case to reach from the ports is a command write that lands while a sweep is in progress. The bench starts a long span and issues a competing command a few cycles into it. It then checks that the per-index write counts, the readback fields and the busy length all still match the first command. Inverted ranges and spans that end at the top index are produced both by directed cases and by random ranges that are swapped some of the time. The top-index span exercises the point where the pointer must stop without wrapping.

// File: rtl/acl_clr_pkg.sv
package acl_clr_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SWEEP = 2'd1,
        ST_EMPTY = 2'd2
    } clr_state_e;

    // Command word positions that software depends on
    localparam int unsigned CMD_W     = 32;
    localparam int unsigned EXEC_BIT  = 0;
    localparam int unsigned START_LSB = 1;
    localparam int unsigned END_LSB   = 12;

endpackage

// File: rtl/acl_clr_lookup_en.sv
module acl_clr_lookup_en #(
    parameter int unsigned NUM_BLOCKS = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr,
    input  logic [NUM_BLOCKS-1:0] wdata,
    output logic [NUM_BLOCKS-1:0] en
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            en <= '0;
        else if (wr)
            en <= wdata;
    end

    // R10: only an explicit write moves the enables
    assert_lut_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !wr |=> $stable(en));

endmodule

// File: rtl/acl_clr_blk_map.sv
module acl_clr_blk_map #(
    parameter int unsigned IDX_W      = 10,
    parameter int unsigned BLK_W      = 3,
    parameter int unsigned BLOCK_SIZE = 128
) (
    input  logic [IDX_W-1:0] idx,
    output logic [BLK_W-1:0] blk
);

    localparam int unsigned BS_LOG = $clog2(BLOCK_SIZE);

    generate
        if ((1 << BS_LOG) == BLOCK_SIZE) begin : g_shift
            logic [IDX_W-1:0] shifted;
            assign shifted = idx >> BS_LOG;
            assign blk     = shifted[BLK_W-1:0];
        end else begin : g_divide
            assign blk = BLK_W'(idx / IDX_W'(BLOCK_SIZE));
        end
    endgenerate

endmodule

// File: rtl/acl_clr_fsm.sv
module acl_clr_fsm
    import acl_clr_pkg::*;
#(
    parameter int unsigned IDX_W = 10,
    parameter int unsigned TOTAL = 1024
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_wr,
    input  logic [CMD_W-1:0] cmd_wdata,
    output logic             busy,
    output logic [IDX_W-1:0] rng_start,
    output logic [IDX_W-1:0] rng_end,
    output logic             mem_we,
    output logic [IDX_W-1:0] mem_addr
);

    clr_state_e       state, state_nxt;
    logic [IDX_W-1:0] ptr;
    logic [IDX_W-1:0] wr_start, wr_end;
    logic             accept, go, armed;
    logic             unused_cmd;

    assign wr_start   = cmd_wdata[START_LSB +: IDX_W];
    assign wr_end     = cmd_wdata[END_LSB +: IDX_W];
    assign accept     = cmd_wr && (state == ST_IDLE);
    assign go         = accept && cmd_wdata[EXEC_BIT];
    assign unused_cmd = ^cmd_wdata;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_SWEEP;
        else
            state <= state_nxt;
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE:  if (go) state_nxt = (wr_end < wr_start) ? ST_EMPTY : ST_SWEEP;
            ST_SWEEP: if (ptr == rng_end) state_nxt = ST_IDLE;
            ST_EMPTY: state_nxt = ST_IDLE;
            default:  state_nxt = ST_IDLE;
        endcase
    end

    // range fields and sweep pointer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rng_start <= '0;
            rng_end   <= IDX_W'(TOTAL - 1);
            ptr       <= '0;
        end else if (accept) begin
            rng_start <= wr_start;
            rng_end   <= wr_end;
            ptr       <= wr_start;
        end else if (state == ST_SWEEP && ptr != rng_end) begin
            ptr <= ptr + 1'b1;
        end
    end

    // outputs
    always_comb begin
        busy     = (state != ST_IDLE);
        mem_we   = (state == ST_SWEEP);
        mem_addr = ptr;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    assert_busy_locks_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && busy && $past(busy)) |-> ($stable(rng_start) && $stable(rng_end)));

    assert_ascending_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && mem_we && $past(mem_we)) |-> (mem_addr - $past(mem_addr) == IDX_W'(1)));

    assert_stop_at_last_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $fell(mem_we)) |-> ($past(mem_addr) == $past(rng_end)));

    assert_empty_one_cycle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_EMPTY) |=> (state == ST_IDLE));

endmodule

// File: rtl/acl_range_clear.sv
module acl_range_clear
    import acl_clr_pkg::*;
#(
    parameter int unsigned NUM_BLOCKS = 8,
    parameter int unsigned BLOCK_SIZE = 128,
    parameter int unsigned ENTRY_W    = 64,
    parameter int unsigned IDX_W      = $clog2(NUM_BLOCKS * BLOCK_SIZE),
    parameter int unsigned BLK_W      = (NUM_BLOCKS > 1) ? $clog2(NUM_BLOCKS) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cmd_wr,
    input  logic [31:0]           cmd_wdata,
    output logic [31:0]           cmd_rdata,
    input  logic                  lut_wr,
    input  logic [NUM_BLOCKS-1:0] lut_wdata,
    output logic [NUM_BLOCKS-1:0] lut_en,
    output logic                  mem_we,
    output logic [IDX_W-1:0]      mem_addr,
    output logic [BLK_W-1:0]      mem_blk,
    output logic [ENTRY_W-1:0]    mem_wdata
);

    localparam int unsigned TOTAL = NUM_BLOCKS * BLOCK_SIZE;

    logic             busy;
    logic [IDX_W-1:0] rng_start, rng_end;

    acl_clr_fsm #(.IDX_W(IDX_W), .TOTAL(TOTAL)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_wr    (cmd_wr),
        .cmd_wdata (cmd_wdata),
        .busy      (busy),
        .rng_start (rng_start),
        .rng_end   (rng_end),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr)
    );

    acl_clr_blk_map #(.IDX_W(IDX_W), .BLK_W(BLK_W), .BLOCK_SIZE(BLOCK_SIZE)) u_blk (
        .idx (mem_addr),
        .blk (mem_blk)
    );

    acl_clr_lookup_en #(.NUM_BLOCKS(NUM_BLOCKS)) u_lut (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (lut_wr),
        .wdata (lut_wdata),
        .en    (lut_en)
    );

    always_comb begin
        cmd_rdata                       = '0;
        cmd_rdata[EXEC_BIT]             = busy;
        cmd_rdata[START_LSB +: IDX_W]   = rng_start;
        cmd_rdata[END_LSB +: IDX_W]     = rng_end;
    end

    assign mem_wdata = '0;

endmodule

// File: tb/acl_range_clear_bench.sv
`timescale 1ns/1ps
module acl_range_clear_bench;

    localparam int NB    = 8;
    localparam int BS    = 128;
    localparam int TOTAL = NB * BS;
    localparam int IW    = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_wr = 1'b0;
    logic [31:0]   cmd_wdata = '0;
    logic [31:0]   cmd_rdata;
    logic          lut_wr = 1'b0;
    logic [NB-1:0] lut_wdata = '0;
    logic [NB-1:0] lut_en;
    logic          mem_we;
    logic [IW-1:0] mem_addr;
    logic [2:0]    mem_blk;
    logic [63:0]   mem_wdata;

    acl_range_clear u_acl_range_clear (
        .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_wdata(cmd_wdata),
        .cmd_rdata(cmd_rdata), .lut_wr(lut_wr), .lut_wdata(lut_wdata),
        .lut_en(lut_en), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_blk(mem_blk), .mem_wdata(mem_wdata)
    );

    always #2 clk = ~clk;  // 250 MHz

    int n_checks = 0;
    int n_fail   = 0;
    int hits [TOTAL];
    int order_err = 0, blk_err = 0, data_err = 0;
    logic          prev_we = 1'b0;
    logic [IW-1:0] prev_addr = '0;

    // write monitor
    always @(negedge clk) begin
        if (rst_n && mem_we) begin
            hits[mem_addr] = hits[mem_addr] + 1;
            if (prev_we && mem_addr != prev_addr + 1'b1) order_err++;
            if (int'(mem_blk) != int'(mem_addr) / BS) blk_err++;
            if (mem_wdata != '0) data_err++;
        end
        prev_we   = rst_n && mem_we;
        prev_addr = mem_addr;
    end

    function automatic logic [31:0] pack(input int s, input int e, input bit x);
        logic [31:0] w;
        w = '0;
        w[0] = x;
        w[1 +: IW] = s[IW-1:0];
        w[12 +: IW] = e[IW-1:0];
        return w;
    endfunction

    function automatic int exp_busy(input int s, input int e);
        return (e >= s) ? (e - s + 1) : 1;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic clear_hits();
        for (int i = 0; i < TOTAL; i++) hits[i] = 0;
    endtask

    task automatic check_hits(input int s, input int e, input string req);
        int bad = 0, first = -1, act = 0, exp = 0;
        for (int i = 0; i < TOTAL; i++) begin
            int want = (e >= s && i >= s && i <= e) ? 1 : 0;
            if (hits[i] != want) begin
                bad++;
                if (first < 0) begin first = i; act = hits[i]; exp = want; end
            end
        end
        if (bad != 0) $display("  index %0d mismatch", first);
        check(bad == 0, req, act, exp);
    endtask

    task automatic poll_busy(output int cyc);
        cyc = 0;
        while (cmd_rdata[0] && cyc < 5000) begin
            cyc++;
            @(negedge clk);
        end
    endtask

    task automatic run_clear(input int s, input int e, input string req);
        int cyc;
        clear_hits();
        @(negedge clk);
        cmd_wdata = pack(s, e, 1'b1);
        cmd_wr = 1'b1;
        @(negedge clk);
        cmd_wr = 1'b0;
        poll_busy(cyc);
        check(cyc == exp_busy(s, e), {req, " busy length R4"}, cyc, exp_busy(s, e));
        check_hits(s, e, {req, " erased span R3"});
        check(cmd_rdata == pack(s, e, 1'b0), {req, " readback R2"},
              int'(cmd_rdata), int'(pack(s, e, 1'b0)));
    endtask

    initial begin
        #(4ns * 150000);
        n_fail++;
        n_checks++;
        $display("FAIL R4 watchdog: actual 1 expected 0");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        int cyc;
        void'($urandom(32'd1234));
        clear_hits();
        repeat (3) @(negedge clk);
        // R1: reset state and power-up erase of the whole table
        check(cmd_rdata == pack(0, TOTAL - 1, 1'b1), "R1 reset readback",
              int'(cmd_rdata), int'(pack(0, TOTAL - 1, 1'b1)));
        check(lut_en == '0, "R10 reset enables", int'(lut_en), 0);
        rst_n = 1'b1;
        poll_busy(cyc);
        check(cyc == TOTAL, "R1 init busy length", cyc, TOTAL);
        check_hits(0, TOTAL - 1, "R1 init erase");

        // R10: lookup enables
        @(negedge clk);
        lut_wdata = 8'hA5; lut_wr = 1'b1;
        @(negedge clk);
        lut_wr = 1'b0; lut_wdata = 8'h00;
        check(lut_en == 8'hA5, "R10 write", int'(lut_en), 'hA5);

        // directed corners
        run_clear(5, 5, "R5 single");
        check(lut_en == 8'hA5, "R10 untouched by erase", int'(lut_en), 'hA5);
        run_clear(40, 3, "R6 inverted");
        run_clear(TOTAL - 1, TOTAL - 1, "R5 top index");
        run_clear(127, 128, "R9 block boundary");
        run_clear(0, TOTAL - 1, "R3 full table");
        run_clear(1000, TOTAL - 1, "R3 tail");

        // R8: execute bit clear
        clear_hits();
        @(negedge clk);
        cmd_wdata = pack(7, 9, 1'b0); cmd_wr = 1'b1;
        @(negedge clk);
        cmd_wr = 1'b0;
        check(cmd_rdata == pack(7, 9, 1'b0), "R8 fields stored",
              int'(cmd_rdata), int'(pack(7, 9, 1'b0)));
        repeat (5) @(negedge clk);
        check_hits(1, 0, "R8 nothing erased");

        // R7: competing write while busy
        clear_hits();
        @(negedge clk);
        cmd_wdata = pack(100, 300, 1'b1); cmd_wr = 1'b1;
        @(negedge clk);
        cmd_wr = 1'b0;
        repeat (3) @(negedge clk);
        cmd_wdata = pack(0, 5, 1'b1); cmd_wr = 1'b1;
        @(negedge clk);
        cmd_wr = 1'b0;
        check(cmd_rdata == pack(100, 300, 1'b1), "R7 readback during busy",
              int'(cmd_rdata), int'(pack(100, 300, 1'b1)));
        poll_busy(cyc);
        check(cyc == 201 - 4, "R7 remaining busy length", cyc, 197);
        check_hits(100, 300, "R7 span unchanged");

        // random ranges
        for (int k = 0; k < 12; k++) begin
            int s = int'($urandom % TOTAL);
            int e = s + int'($urandom % 48);
            if (e > TOTAL - 1) e = TOTAL - 1;
            if ($urandom % 4 == 0) begin int t = s; s = e; e = t; end
            run_clear(s, e, "R3 random");
        end

        check(order_err == 0, "R3 ascending order", order_err, 0);
        check(blk_err == 0, "R9 block number", blk_err, 0);
        check(data_err == 0, "R9 zero data", data_err, 0);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule